// File: doc/BRIEF.md
# Two-Tone FSK Bit Demodulator

This block recovers the data bits of a low-frequency transponder reply that reaches the chip as a one-bit comparator (zero-crossing) signal. The signal is brought into the clock domain by a synchronizer chain. It is then looked at only on cycles that carry the sample-rate enable, nominally a 2 MHz rate. The block times each carrier cycle as the number of samples between two successive rising edges.

The two tones sit only about 8 percent apart. A longer cycle of about 16.2 samples (123.2 kHz) stands for a one, and a shorter cycle of about 14.9 samples (134.2 kHz) stands for a zero. A single period cannot reliably tell them apart, so the block adds the periods of sixteen carrier cycles and compares the total against a fixed threshold. Each decided bit leaves with a one-cycle strobe.

Software or a controller pulses `start` to open a capture and `abort` to close it at once. Capture also recovers by itself after the carrier drops out.

Top module: `fsk_tone_demod`

## Requirements
- R1: After reset `capturing`, `bit_valid` and `carrier_lost` are all 0.
- R2: While `capturing` is 0, edges on `zc_in` produce no `bit_valid`. A `start` pulse sets `capturing` to 1 on the following clock.
- R3: The first rising edge seen after `start`, or after a carrier loss, only sets the timing reference. Each following group of 16 periods produces exactly one `bit_valid` pulse, one clock wide.
- R4: A period is the number of `sample_en` samples from one rising edge of the synchronized input to the next. The input passes two synchronizer flops before edge detection, and only `sample_en` cycles are observed.
- R5: `bit_data` is 1 when the sum of the 16 periods of the bit exceeds 248 samples, the long low tone. It is 0 when the sum is 248 or less. A sum of exactly 248 gives 0 and a sum of 249 gives 1.
- R6: When 40 samples pass after the reference edge without a new rising edge, `carrier_lost` goes to 1 and the partial bit is discarded. The next rising edge re-arms the reference and clears `carrier_lost`.
- R7: `abort` clears `capturing` on the next clock and has priority over a simultaneous `start`. No `bit_valid` appears in the abort cycle or afterwards until a new `start`.
- R8: Bits stream back to back. The edge that closes one bit also opens the next, with no re-arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | Sample-rate enable; the input is observed only when high |
| zc_in | input | 1 | Asynchronous comparator output of the carrier |
| start | input | 1 | Pulse that opens a capture |
| abort | input | 1 | Stops the capture at once |
| capturing | output | 1 | High while a capture is open |
| bit_valid | output | 1 | One-clock strobe for a decided bit |
| bit_data | output | 1 | Decided bit, valid with `bit_valid` |
| carrier_lost | output | 1 | Set when the carrier times out, cleared on the next rising edge or start |

## Verification
The bench drives period sums of exactly 248 and 249 samples. A design with an off-by-one comparison, or one that counted periods one sample short, would flip one of those two bits. It opens a capture with a lone rising edge and expects no period from it. A design that timed that edge against an earlier one would emit an extra or shifted bit. It breaks the carrier in the middle of a bit and expects exactly one bit after recovery, which shows up a design that keeps the partial sum. It aborts halfway through a bit while the carrier keeps running, which exposes a design that finishes the pending bit or keeps capturing.

// File: rtl/fsk_demod_pkg.sv
// Shared types for the two-tone FSK demodulator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package fsk_demod_pkg;

    // Timing-reference state of the period meter.
    typedef enum logic {
        MTR_NO_REF   = 1'b0,
        MTR_HAVE_REF = 1'b1
    } meter_state_e;

    // Capture control state of the top level.
    typedef enum logic {
        CAP_OFF = 1'b0,
        CAP_ON  = 1'b1
    } cap_state_e;

endpackage

// File: rtl/fsk_zc_edge.sv
// Synchronizes the asynchronous comparator input through SYNC_STAGES flops,
// then finds rising edges among the cycles flagged by sample_en.
// Outputs are registered: samp_stb marks a sample, rise_stb marks a sample
// that saw low-to-high. Assumes SYNC_STAGES >= 2.
module fsk_zc_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic zc_in,
    output logic samp_stb,
    output logic rise_stb
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   sync_out;

    assign sync_out = sync_q[SYNC_STAGES-1];

    // First synchronizer flop takes the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= zc_in;
    end

    // Remaining synchronizer flops form a plain chain.
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[g] <= 1'b0;
            else        sync_q[g] <= sync_q[g-1];
        end
    end

    // Sampled edge detection, registered toward the period meter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= 1'b0;
            samp_stb <= 1'b0;
            rise_stb <= 1'b0;
        end else begin
            samp_stb <= sample_en;
            rise_stb <= sample_en & sync_out & ~prev_q;
            if (sample_en) prev_q <= sync_out;
        end
    end

    // R4: an edge is only ever reported on a sample
    assert_rise_on_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> samp_stb);

endmodule

// File: rtl/fsk_period_meter.sv
// Counts samples between successive rising edges. The first edge after a
// clear only sets the reference (arm_stb). Later edges report the period
// (per_stb/per_val). LOSS_LIMIT samples without an edge give lost_stb and
// drop the reference. Assumes rise_stb is only set together with samp_stb.
module fsk_period_meter
    import fsk_demod_pkg::*;
#(
    parameter int LOSS_LIMIT = 40,
    localparam int CNT_W     = $clog2(LOSS_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             samp_stb,
    input  logic             rise_stb,
    output logic             arm_stb,
    output logic             per_stb,
    output logic [CNT_W-1:0] per_val,
    output logic             lost_stb
);
    meter_state_e     state_q;
    logic [CNT_W-1:0] cnt_q;

    // Period counting, reference tracking and loss timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q  <= MTR_NO_REF;
            cnt_q    <= '0;
            arm_stb  <= 1'b0;
            per_stb  <= 1'b0;
            per_val  <= '0;
            lost_stb <= 1'b0;
        end else begin
            arm_stb  <= 1'b0;
            per_stb  <= 1'b0;
            lost_stb <= 1'b0;
            if (samp_stb) begin
                if (rise_stb) begin
                    if (state_q == MTR_HAVE_REF) begin
                        per_stb <= 1'b1;
                        per_val <= cnt_q + 1'b1;
                    end else begin
                        arm_stb <= 1'b1;
                    end
                    state_q <= MTR_HAVE_REF;
                    cnt_q   <= '0;
                end else if (state_q == MTR_HAVE_REF) begin
                    if (cnt_q == CNT_W'(LOSS_LIMIT - 1)) begin
                        lost_stb <= 1'b1;
                        state_q  <= MTR_NO_REF;
                        cnt_q    <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    // R6: no reported period reaches past the loss limit
    assert_period_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        per_stb |-> (per_val <= CNT_W'(LOSS_LIMIT)));
    // R4: rising edges need a low sample between them, so a period is >= 2
    assert_period_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        per_stb |-> (per_val >= CNT_W'(2)));
    // R6: loss and a measured period never coincide
    assert_loss_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lost_stb |-> !per_stb && !arm_stb);

endmodule

// File: rtl/fsk_bit_slicer.sv
// Sums CYCLES_PER_BIT periods and decides the bit: a sum above THRESH_SUM
// is the long (low) tone and gives 1. Emits a one-clock bit_stb. Assumes
// each period is at most MAX_PERIOD. clr drops any partial bit.
module fsk_bit_slicer #(
    parameter int CYCLES_PER_BIT = 16,
    parameter int MAX_PERIOD     = 40,
    parameter int THRESH_SUM     = 248,
    localparam int PER_W         = $clog2(MAX_PERIOD + 1),
    localparam int SUM_W         = $clog2(CYCLES_PER_BIT * MAX_PERIOD + 1),
    localparam int CYC_W         = $clog2(CYCLES_PER_BIT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             per_stb,
    input  logic [PER_W-1:0] per_val,
    output logic             bit_stb,
    output logic             bit_val
);
    logic [CYC_W-1:0] cyc_q;
    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] sum_next;

    // Running total including the period that arrives now.
    always_comb begin
        sum_next = sum_q + SUM_W'(per_val);
    end

    // Accumulate periods and slice at the end of each group.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cyc_q   <= '0;
            sum_q   <= '0;
            bit_stb <= 1'b0;
            bit_val <= 1'b0;
        end else begin
            bit_stb <= 1'b0;
            if (per_stb) begin
                if (cyc_q == CYC_W'(CYCLES_PER_BIT - 1)) begin
                    bit_stb <= 1'b1;
                    bit_val <= (sum_next > SUM_W'(THRESH_SUM));
                    cyc_q   <= '0;
                    sum_q   <= '0;
                end else begin
                    cyc_q <= cyc_q + 1'b1;
                    sum_q <= sum_next;
                end
            end
        end
    end

    // R3: a bit takes many periods, so strobes never come back to back
    assert_bit_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);
    // R3: a bit is only decided on the cycle after a period arrives
    assert_bit_after_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_stb) |-> $past(per_stb));

endmodule

// File: rtl/fsk_tone_demod.sv
// Top of the two-tone FSK demodulator: capture control with start/abort,
// edge front end, period meter and bit slicer. Assumes sample_en is a
// periodic enable at the nominal sample rate and zc_in is asynchronous.
module fsk_tone_demod #(
    parameter int SYNC_STAGES    = 2,
    parameter int CYCLES_PER_BIT = 16,
    parameter int LOSS_LIMIT     = 40,
    parameter int THRESH_SUM     = 248
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic zc_in,
    input  logic start,
    input  logic abort,
    output logic capturing,
    output logic bit_valid,
    output logic bit_data,
    output logic carrier_lost
);
    import fsk_demod_pkg::*;

    localparam int PER_W = $clog2(LOSS_LIMIT + 1);

    cap_state_e       cap_q;
    logic             samp_stb;
    logic             rise_stb;
    logic             arm_stb;
    logic             per_stb;
    logic [PER_W-1:0] per_val;
    logic             lost_stb;
    logic             bit_stb;
    logic             meter_clr;
    logic             slicer_clr;
    logic             lost_q;

    // Abort acts in its own cycle, not only once capture has dropped.
    always_comb begin
        meter_clr  = (cap_q == CAP_OFF) | abort;
        slicer_clr = meter_clr | lost_stb;
    end

    // Capture control: abort wins over start.
    always_ff @(posedge clk) begin
        if (!rst_n)     cap_q <= CAP_OFF;
        else if (abort) cap_q <= CAP_OFF;
        else if (start) cap_q <= CAP_ON;
    end

    // Carrier-loss flag: set by timeout, cleared by re-arm or a new start.
    always_ff @(posedge clk) begin
        if (!rst_n)                 lost_q <= 1'b0;
        else if (lost_stb)          lost_q <= 1'b1;
        else if (arm_stb || start)  lost_q <= 1'b0;
    end

    fsk_zc_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_en(sample_en),
        .zc_in    (zc_in),
        .samp_stb (samp_stb),
        .rise_stb (rise_stb)
    );

    fsk_period_meter #(
        .LOSS_LIMIT(LOSS_LIMIT)
    ) meter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (meter_clr),
        .samp_stb(samp_stb),
        .rise_stb(rise_stb),
        .arm_stb (arm_stb),
        .per_stb (per_stb),
        .per_val (per_val),
        .lost_stb(lost_stb)
    );

    fsk_bit_slicer #(
        .CYCLES_PER_BIT(CYCLES_PER_BIT),
        .MAX_PERIOD    (LOSS_LIMIT),
        .THRESH_SUM    (THRESH_SUM)
    ) slicer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (slicer_clr),
        .per_stb(per_stb),
        .per_val(per_val),
        .bit_stb(bit_stb),
        .bit_val(bit_data)
    );

    assign capturing    = (cap_q == CAP_ON);
    assign bit_valid    = bit_stb & ~abort;
    assign carrier_lost = lost_q;

    // R7: abort closes the capture on the next clock
    assert_abort_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !capturing);
    // R7: no bit leaves in an abort cycle
    assert_abort_no_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !bit_valid);
    // R2: bits only leave while a capture is open
    assert_bit_needs_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> capturing);
    // R6: the loss flag only rises after a timeout from the meter
    assert_lost_from_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier_lost) |-> $past(lost_stb));

endmodule

// File: tb/fsk_tone_demod_tb.sv
// Directed bench for the two-tone FSK demodulator.
module fsk_tone_demod_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_en = 1'b0;
    logic zc_in = 1'b0;
    logic start = 1'b0;
    logic abort = 1'b0;
    logic capturing, bit_valid, bit_data, carrier_lost;

    int total = 0;
    int bad = 0;
    int nb = 0;
    logic bits [0:63];
    int cycles = 0;

    always #2.5 clk = ~clk;

    fsk_tone_demod dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_en   (sample_en),
        .zc_in       (zc_in),
        .start       (start),
        .abort       (abort),
        .capturing   (capturing),
        .bit_valid   (bit_valid),
        .bit_data    (bit_data),
        .carrier_lost(carrier_lost)
    );

    // Sample enable every other clock.
    always @(posedge clk) sample_en <= rst_n ? ~sample_en : 1'b0;

    // Record decided bits away from the active edge.
    always @(negedge clk) begin
        if (bit_valid) begin
            if (nb < 64) bits[nb] = bit_data;
            nb++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: act=%0d expected<150000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one sample value, changing right after a sampling clock.
    task automatic drive(input logic v);
        @(negedge clk);
        while (!sample_en) @(negedge clk);
        zc_in = v;
    endtask

    // One carrier cycle of n samples: rising edge first, then low half.
    task automatic send_period(input int n);
        for (int i = 0; i < n; i++) drive(i < n / 2);
    endtask

    task automatic idle_low(input int n);
        for (int i = 0; i < n; i++) drive(1'b0);
    endtask

    // Sixteen periods for a tone bit (sum 260 for 1, 236 for 0).
    task automatic send_bit(input logic b);
        for (int i = 0; i < 16; i++) begin
            if (b) send_period((i % 5 == 0) ? 17 : 16);
            else   send_period((i % 4 == 0) ? 14 : 15);
        end
    endtask

    // Sixteen periods adding up to an exact sum.
    task automatic send_sum(input int sum);
        for (int i = 0; i < 16; i++) send_period((i < sum % 16) ? sum / 16 + 1 : sum / 16);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    // Fresh capture: abort, start, quiet line, cleared bit log.
    task automatic session_begin();
        pulse(abort);
        idle_low(4);
        pulse(start);
        idle_low(4);
        nb = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(capturing == 0, "R1 capturing", capturing, 0);
        check(bit_valid == 0, "R1 bit_valid", bit_valid, 0);
        check(carrier_lost == 0, "R1 carrier_lost", carrier_lost, 0);
    endtask

    task automatic t_idle_ignored();
        nb = 0;
        for (int i = 0; i < 40; i++) send_period(16);
        idle_low(6);
        check(nb == 0, "R2 no bits while idle", nb, 0);
        pulse(start);
        @(negedge clk);
        check(capturing == 1, "R2 start opens capture", capturing, 1);
    endtask

    task automatic t_tones();
        logic pat [0:4];
        pat = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
        session_begin();
        for (int k = 0; k < 5; k++) send_bit(pat[k]);
        send_period(16);
        idle_low(6);
        check(nb == 5, "R3 R8 bit count", nb, 5);
        for (int k = 0; k < 5; k++)
            if (k < nb) check(bits[k] == pat[k], "R5 tone bit", int'(bits[k]), int'(pat[k]));
        check(carrier_lost == 0, "R6 no loss on clean carrier", carrier_lost, 0);
    endtask

    task automatic t_threshold();
        session_begin();
        send_sum(248);
        send_sum(249);
        send_sum(16 * 14);
        send_sum(16 * 17);
        send_sum(16 * 30);
        send_sum(16 * 4);
        send_period(16);
        idle_low(6);
        check(nb == 6, "R3 threshold bit count", nb, 6);
        if (nb >= 6) begin
            check(bits[0] == 0, "R5 sum 248", int'(bits[0]), 0);
            check(bits[1] == 1, "R5 sum 249", int'(bits[1]), 1);
            check(bits[2] == 0, "R5 all 14", int'(bits[2]), 0);
            check(bits[3] == 1, "R5 all 17", int'(bits[3]), 1);
            check(bits[4] == 1, "R5 all 30", int'(bits[4]), 1);
            check(bits[5] == 0, "R5 all 4", int'(bits[5]), 0);
        end
    endtask

    task automatic t_loss();
        session_begin();
        for (int i = 0; i < 8; i++) send_period(16);
        idle_low(45);
        check(carrier_lost == 1, "R6 loss flagged", carrier_lost, 1);
        check(nb == 0, "R6 partial bit dropped", nb, 0);
        send_period(16);
        check(carrier_lost == 0, "R6 rearm clears loss", carrier_lost, 0);
        for (int i = 0; i < 15; i++) send_period(16);
        check(nb == 0, "R3 rearm edge not a period", nb, 0);
        send_period(16);
        idle_low(6);
        check(nb == 1, "R6 one bit after recovery", nb, 1);
        if (nb >= 1) check(bits[0] == 1, "R6 recovered bit", int'(bits[0]), 1);
    endtask

    task automatic t_boundary_40();
        session_begin();
        for (int i = 0; i < 16; i++) send_period(40);
        send_period(16);
        idle_low(6);
        check(carrier_lost == 0, "R6 period 40 is not a loss", carrier_lost, 0);
        check(nb == 1, "R6 period 40 bit count", nb, 1);
        if (nb >= 1) check(bits[0] == 1, "R5 long periods", int'(bits[0]), 1);
    endtask

    task automatic t_abort();
        session_begin();
        for (int i = 0; i < 10; i++) send_period(16);
        pulse(abort);
        check(capturing == 0, "R7 abort closes capture", capturing, 0);
        for (int i = 0; i < 40; i++) send_period(16);
        idle_low(6);
        check(nb == 0, "R7 no bits after abort", nb, 0);
        @(negedge clk); start = 1'b1; abort = 1'b1;
        @(negedge clk); start = 1'b0; abort = 1'b0;
        check(capturing == 0, "R7 abort beats start", capturing, 0);
        session_begin();
        send_bit(1'b0);
        send_period(15);
        idle_low(6);
        check(nb == 1, "R7 restart bit count", nb, 1);
        if (nb >= 1) check(bits[0] == 0, "R7 restart bit", int'(bits[0]), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_idle_ignored();
        t_tones();
        t_threshold();
        t_loss();
        t_boundary_40();
        t_abort();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule